// File: doc/BRIEF.md
# Integer Condition Flag Generator

This combinational block derives the four integer condition flags (negative, zero, overflow and carry) after an ALU operation. It takes both operands, the result the datapath produced, a two-bit operation class and the current processor status word. It returns the status word with the flag field rewritten. The block does not recompute the arithmetic. Overflow and carry come only from the sign bits of the two operands and the result. This keeps the logic depth small and independent of the data width.

Three operation classes update the flags: add, subtract and logical. For subtract, the carry flag reports a borrow. Logical operations always leave overflow and carry at zero. A fourth class code passes the status word through unchanged, so an instruction that does not touch the flags can use the same path. Only the four flag bits can change. Every other status bit passes through as it was.

Top module: `ccgen_top`

## Requirements
- R1: For op_class 0 (add), 1 (subtract) or 2 (logical), the negative flag at status bit 23 equals result bit 31.
- R2: For op_class 0, 1 or 2, the zero flag at status bit 22 is 1 exactly when all 32 result bits are 0.
- R3: For op_class 0 (add), the overflow flag at bit 21 is bit 31 of (a & b & ~r) | (~a & ~b & r). When r = a + b, this is signed overflow.
- R4: For op_class 0 (add), the carry flag at bit 20 is bit 31 of (a & b) | ((a | b) & ~r). When r = a + b, this equals bit 32 of the 33-bit unsigned sum.
- R5: For op_class 1 (subtract), the overflow flag at bit 21 is bit 31 of (a & ~b & ~r) | (~a & b & r). When r = a - b, this is signed overflow.
- R6: For op_class 1 (subtract), the carry flag at bit 20 is a borrow: bit 31 of (~a & b) | ((~a | b) & r). When r = a - b, this is 1 exactly when a < b unsigned.
- R7: For op_class 2 (logical), the overflow flag and the carry flag are both 0, whatever their old values were.
- R8: Status bits 31:24 and 19:0 of the output always equal the same bits of the input status word.
- R9: For op_class 3, the output status word equals the input status word in every bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First ALU operand |
| op_b | input | 32 | Second ALU operand |
| result | input | 32 | Value the ALU produced from op_a and op_b |
| op_class | input | 2 | 0 add, 1 subtract, 2 logical, 3 leave flags unchanged |
| status_in | input | 32 | Current processor status word |
| status_out | output | 32 | Status word with the flags at bits 23:20 updated |

## Verification
The carry and overflow assertions compare against a 33-bit arithmetic reference. They use that reference only when the result input really is the sum or the difference of the operands. This is because the flag rules assume a consistent result, and for any other result the bitwise formula is the only definition. The bench holds to this assumption: for add and subtract, every random and corner stimulus drives a result computed in the bench from the operands. Logical-class and hold-class stimulus may use any result, because no assertion ties those classes to the operands.

// File: rtl/ccgen_pkg.sv
package ccgen_pkg;

    typedef enum logic [1:0] {
        CC_ADD   = 2'd0,
        CC_SUB   = 2'd1,
        CC_LOGIC = 2'd2,
        CC_HOLD  = 2'd3
    } cc_class_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic cry;
    } cc_flags_t;

    localparam int unsigned CC_FLAG_W = $bits(cc_flags_t);

    // Flag rules reduced to the three sign bits (operand a, operand b, result).
    function automatic logic add_overflow(input logic sa, input logic sb, input logic sr);
        return (sa & sb & ~sr) | (~sa & ~sb & sr);
    endfunction

    function automatic logic add_carry(input logic sa, input logic sb, input logic sr);
        return (sa & sb) | ((sa | sb) & ~sr);
    endfunction

    function automatic logic sub_overflow(input logic sa, input logic sb, input logic sr);
        return (sa & ~sb & ~sr) | (~sa & sb & sr);
    endfunction

    function automatic logic sub_borrow(input logic sa, input logic sb, input logic sr);
        return (~sa & sb) | ((~sa | sb) & sr);
    endfunction

endpackage

// File: rtl/ccgen_sign_flags.sv
module ccgen_sign_flags #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] result,
    output logic              neg,
    output logic              zero
);
    localparam int unsigned MSB = DATA_W - 1;

    assign neg  = result[MSB];
    assign zero = ~|result;
endmodule

// File: rtl/ccgen_arith_flags.sv
module ccgen_arith_flags
    import ccgen_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] result,
    input  logic              is_sub,
    output logic              ovf,
    output logic              cry
);
    localparam int unsigned MSB = DATA_W - 1;

    logic sa, sb, sr;
    assign sa = op_a[MSB];
    assign sb = op_b[MSB];
    assign sr = result[MSB];

    always_comb begin
        if (is_sub) begin
            ovf = sub_overflow(sa, sb, sr);
            cry = sub_borrow(sa, sb, sr);
        end else begin
            ovf = add_overflow(sa, sb, sr);
            cry = add_carry(sa, sb, sr);
        end
    end

    // Wide arithmetic reference used only by the assertions below.
    logic [DATA_W:0] ref_sum, ref_dif;
    assign ref_sum = {1'b0, op_a} + {1'b0, op_b};
    assign ref_dif = {1'b0, op_a} - {1'b0, op_b};

    always_comb begin
        if (!is_sub && result == ref_sum[MSB:0]) begin
            p_add_carry_r4: assert (cry == ref_sum[DATA_W])
                else $error("add carry differs from 33-bit sum");
            p_add_overflow_r3: assert (ovf == ((sa == sb) && (sr != sa)))
                else $error("add overflow differs from signed reference");
        end
        if (is_sub && result == ref_dif[MSB:0]) begin
            p_sub_borrow_r6: assert (cry == (op_a < op_b))
                else $error("subtract borrow differs from unsigned compare");
            p_sub_overflow_r5: assert (ovf == ((sa != sb) && (sr != sa)))
                else $error("subtract overflow differs from signed reference");
        end
    end
endmodule

// File: rtl/ccgen_merge.sv
module ccgen_merge
    import ccgen_pkg::*;
#(
    parameter int unsigned STATUS_W = 32,
    parameter int unsigned FLAG_LSB = 20
) (
    input  logic [STATUS_W-1:0] status_in,
    input  cc_flags_t           flags,
    input  logic                write_en,
    output logic [STATUS_W-1:0] status_out
);
    localparam int unsigned FLAG_MSB = FLAG_LSB + CC_FLAG_W - 1;

    logic [CC_FLAG_W-1:0] flag_bits;
    assign flag_bits = flags;

    for (genvar i = 0; i < STATUS_W; i++) begin : g_bit
        if (i >= FLAG_LSB && i <= FLAG_MSB) begin : g_flag
            assign status_out[i] = write_en ? flag_bits[i-FLAG_LSB] : status_in[i];
        end else begin : g_keep
            assign status_out[i] = status_in[i];
        end
    end

    always_comb begin
        p_other_bits_kept_r8: assert (status_out[STATUS_W-1:FLAG_MSB+1] == status_in[STATUS_W-1:FLAG_MSB+1]
                                   && status_out[FLAG_LSB-1:0] == status_in[FLAG_LSB-1:0])
            else $error("status bits outside the flag field changed");
    end
endmodule

// File: rtl/ccgen_top.sv
module ccgen_top
    import ccgen_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned STATUS_W = 32,
    parameter int unsigned FLAG_LSB = 20
) (
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic [DATA_W-1:0]   result,
    input  logic [1:0]          op_class,
    input  logic [STATUS_W-1:0] status_in,
    output logic [STATUS_W-1:0] status_out
);
    localparam int unsigned MSB    = DATA_W - 1;
    localparam int unsigned N_POS  = FLAG_LSB + 3;
    localparam int unsigned Z_POS  = FLAG_LSB + 2;
    localparam int unsigned V_POS  = FLAG_LSB + 1;
    localparam int unsigned C_POS  = FLAG_LSB;

    cc_class_e cls;
    assign cls = cc_class_e'(op_class);

    logic neg, zero, ovf_ar, cry_ar;
    cc_flags_t flags;

    ccgen_sign_flags #(.DATA_W(DATA_W)) u_sign (
        .result (result),
        .neg    (neg),
        .zero   (zero)
    );

    ccgen_arith_flags #(.DATA_W(DATA_W)) u_arith (
        .op_a   (op_a),
        .op_b   (op_b),
        .result (result),
        .is_sub (cls == CC_SUB),
        .ovf    (ovf_ar),
        .cry    (cry_ar)
    );

    always_comb begin
        flags.neg  = neg;
        flags.zero = zero;
        // Logical class clears overflow and carry.
        flags.ovf  = (cls == CC_LOGIC) ? 1'b0 : ovf_ar;
        flags.cry  = (cls == CC_LOGIC) ? 1'b0 : cry_ar;
    end

    ccgen_merge #(.STATUS_W(STATUS_W), .FLAG_LSB(FLAG_LSB)) u_merge (
        .status_in  (status_in),
        .flags      (flags),
        .write_en   (cls != CC_HOLD),
        .status_out (status_out)
    );

    always_comb begin
        if (cls != CC_HOLD) begin
            p_neg_follows_msb_r1: assert (status_out[N_POS] == result[MSB])
                else $error("negative flag differs from result sign");
            p_zero_on_clear_result_r2: assert (status_out[Z_POS] == (result == '0))
                else $error("zero flag differs from result compare");
        end
        if (cls == CC_LOGIC) begin
            p_logic_clears_vc_r7: assert (!status_out[V_POS] && !status_out[C_POS])
                else $error("logical class left overflow or carry set");
        end
        if (cls == CC_HOLD) begin
            p_hold_passes_status_r9: assert (status_out == status_in)
                else $error("hold class altered the status word");
        end
    end
endmodule

// File: tb/ccgen_top_bench.sv
module ccgen_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a, op_b, result, status_in, status_out;
    logic [1:0]  op_class;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ccgen_top u_ccgen_top (
        .op_a       (op_a),
        .op_b       (op_b),
        .result     (result),
        .op_class   (op_class),
        .status_in  (status_in),
        .status_out (status_out)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic [1:0]  cls;
        logic [31:0] old;
        logic [3:0]  nzvc;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{32'h7FFFFFFF, 32'h00000001, 32'h80000000, 2'd0, 32'h00000000, 4'hA}, // R3 add overflow
        '{32'hFFFFFFFF, 32'h00000001, 32'h00000000, 2'd0, 32'hFFFFFFFF, 4'h5}, // R4 add carry
        '{32'h80000000, 32'h80000000, 32'h00000000, 2'd0, 32'h12345678, 4'h7}, // R3 R4
        '{32'h00000000, 32'h00000001, 32'hFFFFFFFF, 2'd1, 32'h0F0F0F0F, 4'h9}, // R6 borrow
        '{32'h80000000, 32'h00000001, 32'h7FFFFFFF, 2'd1, 32'hA5A5A5A5, 4'h2}, // R5 sub overflow
        '{32'h00000005, 32'h00000005, 32'h00000000, 2'd1, 32'h00F00000, 4'h4}, // R2 zero
        '{32'hFFFFFFFF, 32'h80000000, 32'h80000000, 2'd2, 32'h00F00000, 4'h8}, // R7 clears V C
        '{32'h12345678, 32'h00000000, 32'h00000000, 2'd2, 32'hFFFFFFFF, 4'h4}, // R7 zero
        '{32'h00000001, 32'h00000002, 32'h00000003, 2'd3, 32'hDEADBEEF, 4'hA}, // R9 hold
        '{32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 2'd1, 32'h55555555, 4'hB}  // R5 R6
    };

    function automatic logic [31:0] with_flags(input logic [31:0] old, input logic [3:0] nzvc);
        return (old & ~32'h00F00000) | ({28'd0, nzvc} << 20);
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [31:0] r,
                         input logic [1:0] cls, input logic [31:0] old);
        @(negedge clk);
        op_a = a; op_b = b; result = r; op_class = cls; status_in = old;
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] expv);
        checks++;
        if (status_out !== expv) begin
            errors++;
            $display("FAIL %s: status_out=%08h expected=%08h (a=%08h b=%08h r=%08h cls=%0d)",
                     req, status_out, expv, op_a, op_b, result, op_class);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        op_a = '0; op_b = '0; result = '0; op_class = 2'd0; status_in = '0;
        repeat (3) @(posedge clk);
        // Reset state: zero inputs give only the zero flag (R2).
        #2;
        check("R2 reset", 32'h00400000);
        rst = 1'b0;

        // Table walk: R1 to R9.
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].a, VECS[i].b, VECS[i].r, VECS[i].cls, VECS[i].old);
            check($sformatf("R1-table%0d", i), with_flags(VECS[i].old, VECS[i].nzvc));
        end

        // Random add against 33-bit reference: R1 R2 R3 R4 R8.
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b, st;
            logic [32:0] s;
            a = $urandom; b = $urandom; st = $urandom;
            if (i % 4 == 0) a = (i % 8 == 0) ? 32'h7FFFFFFF : 32'hFFFFFFFF;
            if (i % 6 == 0) b = (i % 12 == 0) ? 32'h80000000 : 32'h00000000;
            s = {1'b0, a} + {1'b0, b};
            apply(a, b, s[31:0], 2'd0, st);
            check("R3 R4 add", with_flags(st, {s[31], s[31:0] == 0,
                  (a[31] == b[31]) && (s[31] != a[31]), s[32]}));
        end

        // Random subtract: R5 R6 R8.
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b, st;
            logic [32:0] d;
            a = $urandom; b = $urandom; st = $urandom;
            if (i % 5 == 0) b = a;
            if (i % 7 == 0) a = 32'h80000000;
            if (i % 9 == 0) b = 32'hFFFFFFFF;
            d = {1'b0, a} - {1'b0, b};
            apply(a, b, d[31:0], 2'd1, st);
            check("R5 R6 sub", with_flags(st, {d[31], d[31:0] == 0,
                  (a[31] != b[31]) && (d[31] != a[31]), a < b}));
        end

        // Random logical: R7 R8.
        for (int i = 0; i < 200; i++) begin
            logic [31:0] a, b, r, st;
            a = $urandom; b = $urandom; st = $urandom | 32'h00300000;
            r = (i % 3 == 0) ? (a & b) : ((i % 3 == 1) ? (a | b) : (a ^ b));
            if (i % 10 == 0) r = 32'h0;
            apply(a, b, r, 2'd2, st);
            check("R7 logic", with_flags(st, {r[31], r == 0, 2'b00}));
        end

        // Hold class: R9.
        for (int i = 0; i < 100; i++) begin
            logic [31:0] st;
            st = $urandom;
            apply($urandom, $urandom, $urandom, 2'd3, st);
            check("R9 hold", st);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule